// File: doc/BRIEF.md
# Two-Path Break-Before-Make Switch Scheduler

This block times two switch-enable outputs that take turns opening one of two transmission paths onto a shared link. The schedule repeats every period of a programmable number of clock cycles. A free-running period counter provides the time base, and every switching event is set as an absolute count within the period. A one-cycle pulse marks the first cycle of each period, so that traffic sources can align their frames to the schedule.

The schedule is set by two hand-over points and a dead time. At the release point of path A, path A switches off. Path B then switches on `cfg_dead` cycles later. The release point of path B starts the reverse hand-over in the same way. Each path's deactivation time is therefore its own release point, and its activation time is the other path's release point plus the dead time. The dead time is a 4-bit field, so it ranges from 0 to 15 cycles; 4 is the usual setting.

The configuration is captured at period boundaries, so a schedule is never torn in the middle of a period. A schedule that is impossible raises an error flag and holds both paths off. A run-time guard counter stops a path from opening until the other path has been dark for the dead time, even when a new configuration takes over at a boundary. A current-path output tells which path owns the link at the moment.

Top module: `twopath_sched`

## Requirements
- R1: While running, a count steps through 0 to P-1 and then returns to 0, where P is the captured `cfg_period`. `period_start` is high in exactly the cycles where the count is 0, and the counter keeps stepping even when `cfg_err` is high.
- R2: While idle, both enables and `period_start` are low. When `run` is sampled high while idle, the next cycle is count 0 with `period_start` high.
- R3: When `run` is sampled low while running, the next cycle has `en_a`, `en_b` and `period_start` low, and the block returns to idle.
- R4: With a valid schedule, `en_a` is high in the cycles where the count lies in the circular interval [(rel_b + dead) mod P, rel_a). Here rel_a is the release point of path A and rel_b is the release point of path B.
- R5: With a valid schedule, `en_b` is high in the cycles where the count lies in the circular interval [(rel_a + dead) mod P, rel_b).
- R6: `en_a` and `en_b` are never high in the same cycle.
- R7: The dead time is taken from the 4-bit `cfg_dead` and ranges from 0 to 15. With 0, the incoming path opens in the same cycle the outgoing path closes. With 15, the incoming path opens 15 cycles after that.
- R8: `cfg_err` is high, and both enables are held low, when any of these holds for the captured values:
  - rel_a ≥ P;
  - rel_b ≥ P;
  - rel_a = rel_b;
  - the forward distance from either release point to the other is ≤ dead.
- R9: The configuration inputs are captured every cycle while idle and at the clock edge where the count wraps. A change in the middle of a period has no effect on the outputs until the next `period_start`.
- R10: `cur_path` is 1 (path B's turn) in the cycles where the count lies in the circular interval [rel_a, rel_b), and 0 otherwise. It is also 0 while idle or while `cfg_err` is high.
- R11: A path's enable rises only after the other path's enable has been low for at least `dead` consecutive cycles. This also holds across a period boundary where a new configuration takes over.
- R12: During and right after reset, both enables, `period_start` and `cur_path` are low. The captured configuration holds valid defaults (P = 528, rel_a = 264, rel_b = 0, dead = 4), so `cfg_err` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Starts (high) or stops (low) the schedule |
| cfg_period | input | CW | Period length P in cycles |
| cfg_rel_a | input | CW | Count at which path A is released |
| cfg_rel_b | input | CW | Count at which path B is released |
| cfg_dead | input | DW | Dead time in cycles |
| en_a | output | 1 | Switch enable of path A |
| en_b | output | 1 | Switch enable of path B |
| period_start | output | 1 | High in the first cycle of every period |
| cur_path | output | 1 | 1 when it is path B's turn, 0 for path A |
| cfg_err | output | 1 | Captured schedule is invalid |

## Verification
The bench targets several corner cases, and each one matches a specific design error:
- **Dead-time edges.** The incoming path must open exactly `dead` cycles after the release, both at dead time 0 and at dead time 15. An off-by-one in the modular addition would open a path one cycle early or late.
- **Wrap-around windows.** A window that crosses count 0 exercises the circular interval test. A wrong compare would drop the wrapped part of the window, or turn it on for the whole period.
- **Mid-period reconfiguration.** The old schedule must hold until the boundary. A design that used the live inputs would switch in the middle of a frame.
- **Boundary hand-over under a larger dead time.** The old path stays on up to the last cycle of the period, while the new window starts at count 0. A design without the guard counter would leave both paths dark for less than the dead time.
- **Invalid schedules.** The bench tries each error condition and a distance just one cycle above the dead time. A design with a wrong error rule would either let windows collide, or reject a valid one-cycle window.

// File: rtl/twopath_pkg.sv
package twopath_pkg;

  typedef int unsigned u32_t;

  // (x + d) reduced once modulo p; exact when x < p and d < p
  function automatic u32_t mod_add(input u32_t x, input u32_t d, input u32_t p);
    u32_t s;
    s = x + d;
    return (s >= p) ? (s - p) : s;
  endfunction

  // forward distance on a ring of p positions, from 'from' to 'to'
  function automatic u32_t fwd_dist(input u32_t from, input u32_t to, input u32_t p);
    return (to >= from) ? (to - from) : (to + p - from);
  endfunction

  // membership of c in the circular half-open span [s, e)
  function automatic logic in_span(input u32_t c, input u32_t s, input u32_t e);
    if (s <= e) return (c >= s) && (c < e);
    return (c >= s) || (c < e);
  endfunction

  // schedule validity: both release points on the ring, distinct, and
  // each hand-over leaving a non-empty window after the dead time
  function automatic logic sched_bad(input u32_t p, input u32_t ra,
                                     input u32_t rb, input u32_t d);
    if (ra >= p || rb >= p) return 1'b1;
    if (ra == rb) return 1'b1;
    return (fwd_dist(ra, rb, p) <= d) || (fwd_dist(rb, ra, p) <= d);
  endfunction

endpackage

// File: rtl/twopath_cfg_shadow.sv
module twopath_cfg_shadow
  import twopath_pkg::*;
#(
  parameter int CW          = 10,
  parameter int DW          = 4,
  parameter int DEF_PERIOD  = 528,
  parameter int DEF_REL_A   = 264,
  parameter int DEF_REL_B   = 0,
  parameter int DEF_DEAD    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_rel_a,
  input  logic [CW-1:0] cfg_rel_b,
  input  logic [DW-1:0] cfg_dead,
  output logic [CW-1:0] sh_period,
  output logic [CW-1:0] sh_rel_a,
  output logic [CW-1:0] sh_rel_b,
  output logic [DW-1:0] sh_dead,
  output logic          sh_bad,
  output logic [CW-1:0] on_a_at,
  output logic [CW-1:0] on_b_at
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_period <= CW'(DEF_PERIOD);
      sh_rel_a  <= CW'(DEF_REL_A);
      sh_rel_b  <= CW'(DEF_REL_B);
      sh_dead   <= DW'(DEF_DEAD);
    end else if (load) begin
      sh_period <= cfg_period;
      sh_rel_a  <= cfg_rel_a;
      sh_rel_b  <= cfg_rel_b;
      sh_dead   <= cfg_dead;
    end
  end

  assign sh_bad = sched_bad(u32_t'(sh_period), u32_t'(sh_rel_a),
                            u32_t'(sh_rel_b), u32_t'(sh_dead));

  // activation point of each path: the other path's release plus dead time
  assign on_a_at = CW'(mod_add(u32_t'(sh_rel_b), u32_t'(sh_dead), u32_t'(sh_period)));
  assign on_b_at = CW'(mod_add(u32_t'(sh_rel_a), u32_t'(sh_dead), u32_t'(sh_period)));

endmodule

// File: rtl/twopath_period_ctr.sv
module twopath_period_ctr
  import twopath_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt,
  output logic          running,
  output logic          wrap,
  output logic          start
);

  // last cycle of the period; periods of 0 or 1 wrap on every cycle
  assign wrap  = running && ((u32_t'(cnt) + 1) >= u32_t'(period));
  assign start = running && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (!running) begin
      cnt     <= '0;
      running <= run;
    end else if (!run) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (wrap) begin
      cnt     <= '0;
    end else begin
      cnt     <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/twopath_path_gate.sv
module twopath_path_gate
  import twopath_pkg::*;
#(
  parameter int CW = 10,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          running,
  input  logic          bad,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] rel_a,
  input  logic [CW-1:0] rel_b,
  input  logic [CW-1:0] on_a_at,
  input  logic [CW-1:0] on_b_at,
  input  logic [DW-1:0] dead,
  output logic          en_a,
  output logic          en_b,
  output logic          turn_b
);

  localparam int GW = DW + 1;

  logic                 live;
  logic [1:0][CW-1:0]   rel_w;
  logic [1:0][CW-1:0]   on_w;
  logic [1:0][GW-1:0]   gap_w;
  logic [1:0]           en_w;

  assign live     = running && !bad;
  assign rel_w[0] = rel_a;
  assign rel_w[1] = rel_b;
  assign on_w[0]  = on_a_at;
  assign on_w[1]  = on_b_at;

  for (genvar p = 0; p < 2; p++) begin : g_path
    logic          win;
    logic [GW-1:0] gap_q;   // cycles this path has been dark, saturating

    assign win      = in_span(u32_t'(cnt), u32_t'(on_w[p]), u32_t'(rel_w[p]));
    assign en_w[p]  = live && win && (gap_w[1-p] >= {1'b0, dead});
    assign gap_w[p] = gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             gap_q <= '1;
      else if (en_w[p])       gap_q <= '0;
      else if (gap_q != '1)   gap_q <= gap_q + 1'b1;
    end
  end

  assign en_a   = en_w[0];
  assign en_b   = en_w[1];
  assign turn_b = live && in_span(u32_t'(cnt), u32_t'(rel_a), u32_t'(rel_b));

endmodule

// File: rtl/twopath_sched.sv
module twopath_sched
  import twopath_pkg::*;
#(
  parameter int CW         = 10,
  parameter int DW         = 4,
  parameter int DEF_PERIOD = 528,
  parameter int DEF_REL_A  = 264,
  parameter int DEF_REL_B  = 0,
  parameter int DEF_DEAD   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_rel_a,
  input  logic [CW-1:0] cfg_rel_b,
  input  logic [DW-1:0] cfg_dead,
  output logic          en_a,
  output logic          en_b,
  output logic          period_start,
  output logic          cur_path,
  output logic          cfg_err
);

  // named internal events, visible to the bound checker
  logic [CW-1:0] cnt_q;
  logic          running_q;
  logic          wrap_w;
  logic          load_w;
  logic [CW-1:0] sh_period;
  logic [CW-1:0] sh_rel_a;
  logic [CW-1:0] sh_rel_b;
  logic [DW-1:0] sh_dead;
  logic          sh_bad;
  logic [CW-1:0] on_a_at;
  logic [CW-1:0] on_b_at;

  // capture while idle and on the wrap edge only
  assign load_w = !running_q || wrap_w;

  twopath_cfg_shadow #(
    .CW(CW), .DW(DW), .DEF_PERIOD(DEF_PERIOD), .DEF_REL_A(DEF_REL_A),
    .DEF_REL_B(DEF_REL_B), .DEF_DEAD(DEF_DEAD)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load_w),
    .cfg_period(cfg_period), .cfg_rel_a(cfg_rel_a), .cfg_rel_b(cfg_rel_b),
    .cfg_dead(cfg_dead),
    .sh_period(sh_period), .sh_rel_a(sh_rel_a), .sh_rel_b(sh_rel_b),
    .sh_dead(sh_dead), .sh_bad(sh_bad), .on_a_at(on_a_at), .on_b_at(on_b_at)
  );

  twopath_period_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .run(run), .period(sh_period),
    .cnt(cnt_q), .running(running_q), .wrap(wrap_w), .start(period_start)
  );

  twopath_path_gate #(.CW(CW), .DW(DW)) u_gate (
    .clk(clk), .rst_n(rst_n), .running(running_q), .bad(sh_bad),
    .cnt(cnt_q), .rel_a(sh_rel_a), .rel_b(sh_rel_b),
    .on_a_at(on_a_at), .on_b_at(on_b_at), .dead(sh_dead),
    .en_a(en_a), .en_b(en_b), .turn_b(cur_path)
  );

  assign cfg_err = sh_bad;

endmodule

// File: rtl/twopath_sched_chk.sv
module twopath_sched_chk #(
  parameter int CW = 10,
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          en_a,
  input logic          en_b,
  input logic          period_start,
  input logic          cfg_err,
  input logic          running_q,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] sh_period,
  input logic [DW-1:0] sh_dead
);

  logic [DW:0] dark_a, dark_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dark_a <= '1;
      dark_b <= '1;
    end else begin
      dark_a <= en_a ? '0 : ((dark_a == '1) ? dark_a : dark_a + 1'b1);
      dark_b <= en_b ? '0 : ((dark_b == '1) ? dark_b : dark_b + 1'b1);
    end
  end

  p_count_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !cfg_err) |-> (cnt_q < sh_period));

  p_start_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && !cfg_err && run) |=> !period_start);

  p_first_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_q && run) |=> period_start);

  p_stop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!en_a && !en_b && !period_start));

  p_never_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_a && en_b));

  p_err_holds_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!en_a && !en_b));

  p_guard_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_b) |-> (dark_a >= {1'b0, sh_dead}));

  p_guard_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_a) |-> (dark_b >= {1'b0, sh_dead}));

endmodule

bind twopath_sched twopath_sched_chk #(.CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .en_a(en_a), .en_b(en_b),
  .period_start(period_start), .cfg_err(cfg_err), .running_q(running_q),
  .cnt_q(cnt_q), .sh_period(sh_period), .sh_dead(sh_dead)
);

// File: tb/sim_twopath_sched.sv
module sim_twopath_sched;
  localparam int CW = 10;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          run = 1'b0;
  logic [CW-1:0] cfg_period, cfg_rel_a, cfg_rel_b;
  logic [DW-1:0] cfg_dead;
  logic          en_a, en_b, period_start, cur_path, cfg_err;

  always #5 clk = ~clk;   // 100 MHz

  twopath_sched #(.CW(CW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_period(cfg_period),
    .cfg_rel_a(cfg_rel_a), .cfg_rel_b(cfg_rel_b), .cfg_dead(cfg_dead),
    .en_a(en_a), .en_b(en_b), .period_start(period_start),
    .cur_path(cur_path), .cfg_err(cfg_err)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // behavioural reference: integers and modulo arithmetic
  int m_run = 0, m_cnt = 0, m_p = 528, m_ra = 264, m_rb = 0, m_d = 4;
  int m_ga = 31, m_gb = 31;
  bit m_ea = 0, m_eb = 0, m_sof = 0, m_cur = 0, m_err = 0;

  function automatic bit ref_bad(int p, int ra, int rb, int d);
    if (ra >= p || rb >= p || ra == rb) return 1;
    return (((rb - ra + p) % p) <= d) || (((ra - rb + p) % p) <= d);
  endfunction

  task automatic ref_outputs();
    bit live;
    m_err = ref_bad(m_p, m_ra, m_rb, m_d);
    live  = (m_run != 0) && !m_err;
    m_sof = (m_run != 0) && (m_cnt == 0);
    m_ea = 0; m_eb = 0; m_cur = 0;
    if (live) begin
      m_ea  = (((m_cnt - m_rb - m_d + 2*m_p) % m_p) < (((m_ra - m_rb + m_p) % m_p) - m_d))
              && (m_gb >= m_d);
      m_eb  = (((m_cnt - m_ra - m_d + 2*m_p) % m_p) < (((m_rb - m_ra + m_p) % m_p) - m_d))
              && (m_ga >= m_d);
      m_cur = ((m_cnt - m_ra + m_p) % m_p) < ((m_rb - m_ra + m_p) % m_p);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_p = 528; m_ra = 264; m_rb = 0; m_d = 4;
      m_ga = 31; m_gb = 31;
    end else begin
      bit wrap_now;
      m_ga = m_ea ? 0 : ((m_ga < 31) ? m_ga + 1 : 31);
      m_gb = m_eb ? 0 : ((m_gb < 31) ? m_gb + 1 : 31);
      wrap_now = (m_run != 0) && (m_cnt + 1 >= m_p);
      if (m_run == 0 || wrap_now) begin
        m_p = int'(cfg_period); m_ra = int'(cfg_rel_a);
        m_rb = int'(cfg_rel_b); m_d = int'(cfg_dead);
      end
      if (m_run == 0) begin m_cnt = 0; m_run = run ? 1 : 0; end
      else if (!run) begin m_run = 0; m_cnt = 0; end
      else m_cnt = wrap_now ? 0 : m_cnt + 1;
    end
    ref_outputs();
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit bad;
      bad = 0;
      if (en_a != m_ea) begin bad = 1;
        $display("FAIL R4 en_a at count %0d actual %0b expected %0b", m_cnt, en_a, m_ea); end
      if (en_b != m_eb) begin bad = 1;
        $display("FAIL R5 en_b at count %0d actual %0b expected %0b", m_cnt, en_b, m_eb); end
      if (period_start != m_sof) begin bad = 1;
        $display("FAIL R1 period_start at count %0d actual %0b expected %0b", m_cnt, period_start, m_sof); end
      if (cur_path != m_cur) begin bad = 1;
        $display("FAIL R10 cur_path at count %0d actual %0b expected %0b", m_cnt, cur_path, m_cur); end
      if (cfg_err != m_err) begin bad = 1;
        $display("FAIL R8 cfg_err actual %0b expected %0b", cfg_err, m_err); end
      if (en_a && en_b) begin bad = 1;
        $display("FAIL R6 both enables actual 11 expected not both"); end
      n_chk++;
      if (bad) n_bad++;
    end
  end

  task automatic expect_bit(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wait_cnt(int c);
    do @(negedge clk); while (!(m_run != 0 && m_cnt == c));
  endtask

  task automatic set_cfg(int p, int ra, int rb, int d);
    cfg_period = CW'(p); cfg_rel_a = CW'(ra); cfg_rel_b = CW'(rb); cfg_dead = DW'(d);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    set_cfg(528, 504, 240, 4);
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    expect_bit("R12 en_a in reset", en_a, 1'b0);
    expect_bit("R12 en_b in reset", en_b, 1'b0);
    expect_bit("R12 period_start in reset", period_start, 1'b0);
    expect_bit("R12 cur_path in reset", cur_path, 1'b0);
    expect_bit("R12 cfg_err in reset", cfg_err, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_bit("R2 en_a idle", en_a, 1'b0);
    expect_bit("R2 en_b idle", en_b, 1'b0);
    expect_bit("R2 period_start idle", period_start, 1'b0);

    // R2: first period starts the cycle after run is sampled
    run = 1'b1;
    @(negedge clk);
    expect_bit("R2 first period_start", period_start, 1'b1);
    expect_bit("R5 en_b open at count 0 (wrapped window)", en_b, 1'b1);

    wait_cnt(239);
    expect_bit("R5 en_b before release", en_b, 1'b1);
    expect_bit("R10 cur_path B turn", cur_path, 1'b1);
    wait_cnt(240);
    expect_bit("R5 en_b released", en_b, 1'b0);
    expect_bit("R10 cur_path A turn", cur_path, 1'b0);
    wait_cnt(243);
    expect_bit("R7 en_a dark in dead time", en_a, 1'b0);
    wait_cnt(244);
    expect_bit("R4 R7 en_a opens after 4", en_a, 1'b1);
    wait_cnt(527);
    expect_bit("R1 no pulse at last count", period_start, 1'b0);
    wait_cnt(0);
    expect_bit("R1 pulse on wrap", period_start, 1'b1);

    // R9: mid-period change waits for the boundary
    wait_cnt(100);
    set_cfg(528, 300, 100, 4);
    wait_cnt(150);
    expect_bit("R9 old schedule kept en_b", en_b, 1'b1);
    wait_cnt(103);
    expect_bit("R9 new schedule en_a dark", en_a, 1'b0);
    wait_cnt(104);
    expect_bit("R9 new schedule en_a open", en_a, 1'b1);

    // R3: stop
    run = 1'b0;
    @(negedge clk);
    expect_bit("R3 en_a after stop", en_a, 1'b0);
    expect_bit("R3 en_b after stop", en_b, 1'b0);
    expect_bit("R3 period_start after stop", period_start, 1'b0);

    // R7: dead time 0
    set_cfg(400, 300, 100, 0);
    repeat (2) @(negedge clk);
    run = 1'b1;
    wait_cnt(99);
    expect_bit("R7 dead0 en_b before", en_b, 1'b1);
    wait_cnt(100);
    expect_bit("R7 dead0 en_a same cycle", en_a, 1'b1);
    expect_bit("R7 dead0 en_b off", en_b, 1'b0);
    run = 1'b0;
    repeat (2) @(negedge clk);

    // R7: dead time 15
    set_cfg(64, 40, 10, 15);
    run = 1'b1;
    wait_cnt(24);
    expect_bit("R7 dead15 en_a still dark", en_a, 1'b0);
    wait_cnt(25);
    expect_bit("R7 dead15 en_a open", en_a, 1'b1);
    run = 1'b0;
    repeat (2) @(negedge clk);

    // R11: boundary hand-over into a larger dead time
    set_cfg(64, 0, 10, 0);
    run = 1'b1;
    wait_cnt(40);
    set_cfg(64, 56, 30, 8);
    wait_cnt(0);
    expect_bit("R11 en_b held at count 0", en_b, 1'b0);
    expect_bit("R11 en_a off at count 0", en_a, 1'b0);
    wait_cnt(7);
    expect_bit("R11 en_b held at count 7", en_b, 1'b0);
    wait_cnt(8);
    expect_bit("R11 en_b opens at count 8", en_b, 1'b1);

    // R8: invalid schedules
    wait_cnt(40);
    set_cfg(64, 70, 30, 8);
    wait_cnt(0);
    expect_bit("R8 release beyond period", cfg_err, 1'b1);
    expect_bit("R8 counter still runs", period_start, 1'b1);
    wait_cnt(5);
    expect_bit("R8 enables held off", en_b | en_a, 1'b0);
    set_cfg(64, 20, 20, 8);
    wait_cnt(0);
    expect_bit("R8 equal release points", cfg_err, 1'b1);
    wait_cnt(10);
    set_cfg(64, 20, 24, 4);
    wait_cnt(0);
    expect_bit("R8 distance equal to dead", cfg_err, 1'b1);
    wait_cnt(10);
    set_cfg(64, 20, 25, 4);
    wait_cnt(0);
    expect_bit("R8 distance one above dead", cfg_err, 1'b0);
    wait_cnt(24);
    expect_bit("R5 one-cycle window open", en_b, 1'b1);
    wait_cnt(25);
    expect_bit("R5 one-cycle window closed", en_b, 1'b0);

    run = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule